// File: doc/BRIEF.md
# Rail-Gated Input Hold Bank

This block sits between a group of input pins and the logic that consumes them. A single assertion rail can freeze any chosen subset of the channels. While the rail is high, each chosen channel stops following its pin and presents the value it had when it was blocked. Channels that are not chosen always pass their pin straight through, with no register in the path. When the rail falls, the frozen channels follow their pins again in the same cycle.

The rail has one source, picked by configuration. It can come from a dedicated input pin or from the top bit of a free-running internal counter. A global gate enable turns the whole function off. The rail level appears on an observation output. When gating is off, that output simply forwards a user data bit.

The configuration holds three items: the gate enable, the rail source and the per-channel participation mask. All three load together on a write strobe and reset to zero. Hold storage samples each pin on every clock edge at which the rail is low. A blocked channel therefore presents the pin value from the last edge before the rail went high.

Top module: `gate_hold_top`

## Requirements
- R1: After synchronous reset, the gate enable, the source select and the mask are all zero. `core_out` equals `pin_in` and `obs_out` equals `user_obs_d`.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_gate_en`, `cfg_src_cnt` and `cfg_mask` are loaded together. The new settings act from the cycle after that edge.
- R3: The rail is low whenever the gate enable is 0. With the gate enable at 1 and `cfg_src_cnt` at 0, the rail follows `rail_pin`. With `cfg_src_cnt` at 1, the rail is bit CNT_W-1 of a counter that clears on reset and increments at every clock edge.
- R4: A channel whose mask bit is 0 always shows its pin value combinationally on `core_out`.
- R5: While the rail is high, a channel whose mask bit is 1 shows the pin value sampled at the last rising edge at which the rail was low. Pin changes during the blocked period have no effect on it.
- R6: If a pin changes in the same cycle that the rail rises, the blocked channel shows the value from before the change.
- R7: In any cycle in which the rail is low, every `core_out` bit equals its `pin_in` bit in that same cycle, with no added latency.
- R8: When the gate enable is 1, `obs_out` shows the rail level. When it is 0, `obs_out` shows `user_obs_d`.
- R9: Hold storage samples every channel, whatever its mask bit. A channel added to the mask while the rail is high shows the value captured at the last low-rail edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_gate_en | input | 1 | Global gate enable to load |
| cfg_src_cnt | input | 1 | Rail source to load: 0 pin, 1 counter |
| cfg_mask | input | NCH | Participation mask to load, bit i for channel i |
| rail_pin | input | 1 | Direct rail source |
| user_obs_d | input | 1 | Data forwarded to `obs_out` when gating is off |
| pin_in | input | NCH | Channel pin values |
| core_out | output | NCH | Gated channel values toward the core |
| obs_out | output | 1 | Rail observation or forwarded data |

## Verification
The assertions assume that `pin_in`, `rail_pin`, `user_obs_d` and the configuration inputs change only between clock edges. The capture and hold properties depend on this, because they compare `core_out` with pin values sampled at neighbouring edges. The stimulus drives every input on the falling edge and samples outputs shortly after. The sweep covers all masks under every pairing of gate enable and source. It also toggles `rail_pin` in an irregular pattern and changes pins every cycle, so rail edges and pin changes often land in the same cycle.

// File: rtl/gate_pkg.sv
`timescale 1ns/1ps
package gate_pkg;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_CNT = 1'b1
    } rail_src_e;

    typedef struct packed {
        logic      gate_en;
        rail_src_e src;
    } rail_mode_t;

    function automatic logic rail_pick(input rail_mode_t m,
                                       input logic pin_v,
                                       input logic cnt_v);
        if (!m.gate_en)
            return 1'b0;
        return (m.src == SRC_CNT) ? cnt_v : pin_v;
    endfunction

endpackage

// File: rtl/gate_cfg_reg.sv
`timescale 1ns/1ps
module gate_cfg_reg
    import gate_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  rail_mode_t       mode_d,
    input  logic [NCH-1:0]   mask_d,
    output rail_mode_t       mode_q,
    output logic [NCH-1:0]   mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{gate_en: 1'b0, src: SRC_PIN};
            mask_q <= '0;
        end else if (we) begin
            mode_q <= mode_d;
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/gate_rail_gen.sv
`timescale 1ns/1ps
module gate_rail_gen
    import gate_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  rail_mode_t mode,
    input  logic       rail_pin,
    output logic       rail
);

    localparam int TOP = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign rail = rail_pick(mode, rail_pin, cnt_q[TOP]);

endmodule

// File: rtl/gate_hold_bank.sv
`timescale 1ns/1ps
module gate_hold_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rail,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] core_out
);

    logic [NCH-1:0] hold_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                hold_q[i] <= 1'b0;
            else if (!rail)
                hold_q[i] <= pin_in[i];
        end
        assign core_out[i] = (rail && mask[i]) ? hold_q[i] : pin_in[i];
    end

endmodule

// File: rtl/gate_hold_top.sv
`timescale 1ns/1ps
module gate_hold_top
    import gate_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic           cfg_gate_en,
    input  logic           cfg_src_cnt,
    input  logic [NCH-1:0] cfg_mask,
    input  logic           rail_pin,
    input  logic           user_obs_d,
    input  logic [NCH-1:0] pin_in,
    output logic [NCH-1:0] core_out,
    output logic           obs_out
);

    rail_mode_t     mode_d;
    rail_mode_t     mode_q;
    logic [NCH-1:0] mask_q;
    logic           rail;

    assign mode_d.gate_en = cfg_gate_en;
    assign mode_d.src     = rail_src_e'(cfg_src_cnt);

    gate_cfg_reg #(.NCH(NCH)) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .mode_d (mode_d),
        .mask_d (cfg_mask),
        .mode_q (mode_q),
        .mask_q (mask_q)
    );

    gate_rail_gen #(.CNT_W(CNT_W)) rail_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_q),
        .rail_pin (rail_pin),
        .rail     (rail)
    );

    gate_hold_bank #(.NCH(NCH)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .rail     (rail),
        .mask     (mask_q),
        .pin_in   (pin_in),
        .core_out (core_out)
    );

    assign obs_out = mode_q.gate_en ? rail : user_obs_d;

endmodule

// File: rtl/gate_hold_chk.sv
`timescale 1ns/1ps
module gate_hold_chk
    import gate_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input rail_mode_t     mode,
    input logic [NCH-1:0] mask,
    input logic           rail,
    input logic           rail_pin,
    input logic           user_obs_d,
    input logic [NCH-1:0] pin_in,
    input logic [NCH-1:0] core_out,
    input logic           obs_out
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (mask == '0 && !mode.gate_en));

    assert_rail_off_R3: assert property (@(posedge clk) disable iff (rst)
        !mode.gate_en |-> !rail);

    assert_unmasked_pass_R4: assert property (@(posedge clk) disable iff (rst)
        (core_out & ~mask) == (pin_in & ~mask));

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (rail && $past(rail)) |->
            (((core_out ^ $past(core_out)) & mask & $past(mask)) == '0));

    assert_capture_prev_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rail) |-> ((core_out & mask) == ($past(pin_in) & mask)));

    assert_release_follow_R7: assert property (@(posedge clk) disable iff (rst)
        !rail |-> (core_out == pin_in));

    assert_obs_data_R8: assert property (@(posedge clk) disable iff (rst)
        !mode.gate_en |-> (obs_out == user_obs_d));

    assert_obs_pin_R8: assert property (@(posedge clk) disable iff (rst)
        (mode.gate_en && mode.src == SRC_PIN) |-> (obs_out == rail_pin));

endmodule

bind gate_hold_top gate_hold_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode_q),
    .mask       (mask_q),
    .rail       (rail),
    .rail_pin   (rail_pin),
    .user_obs_d (user_obs_d),
    .pin_in     (pin_in),
    .core_out   (core_out),
    .obs_out    (obs_out)
);

// File: tb/gate_hold_top_tb_top.sv
`timescale 1ns/1ps
module gate_hold_top_tb_top;

    localparam int NCH   = 8;
    localparam int CNT_W = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic           cfg_gate_en = 1'b0;
    logic           cfg_src_cnt = 1'b0;
    logic [NCH-1:0] cfg_mask = '0;
    logic           rail_pin = 1'b0;
    logic           user_obs_d = 1'b0;
    logic [NCH-1:0] pin_in = '0;
    logic [NCH-1:0] core_out;
    logic           obs_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state built from the requirements
    logic [CNT_W-1:0] m_cnt  = '0;
    logic             m_gate = 1'b0;
    logic             m_src  = 1'b0;
    logic [NCH-1:0]   m_mask = '0;
    logic [NCH-1:0]   m_hold = '0;

    always #5 clk = ~clk;

    gate_hold_top #(.NCH(NCH), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_gate_en(cfg_gate_en),
        .cfg_src_cnt(cfg_src_cnt),
        .cfg_mask   (cfg_mask),
        .rail_pin   (rail_pin),
        .user_obs_d (user_obs_d),
        .pin_in     (pin_in),
        .core_out   (core_out),
        .obs_out    (obs_out)
    );

    function automatic logic model_rail();
        if (!m_gate) return 1'b0;
        return m_src ? m_cnt[CNT_W-1] : rail_pin;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_gate = 1'b0; m_src = 1'b0; m_mask = '0; m_hold = '0;
        end else begin
            if (!model_rail()) m_hold = pin_in;
            m_cnt = m_cnt + 1'b1;
            if (cfg_we) begin
                m_gate = cfg_gate_en; m_src = cfg_src_cnt; m_mask = cfg_mask;
            end
        end
    end

    task automatic cmp_vec(input string tag, input logic [NCH-1:0] act,
                           input logic [NCH-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s core_out actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_bit(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s obs_out actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // drive on the falling edge, then compare against the reference
    task automatic step(input logic [NCH-1:0] p, input logic rp, input logic ud,
                        input logic we, input logic g, input logic s,
                        input logic [NCH-1:0] m);
        logic r;
        logic [NCH-1:0] e;
        @(negedge clk);
        pin_in = p; rail_pin = rp; user_obs_d = ud;
        cfg_we = we; cfg_gate_en = g; cfg_src_cnt = s; cfg_mask = m;
        #1;
        r = model_rail();
        e = r ? ((m_hold & m_mask) | (p & ~m_mask)) : p;
        cmp_vec(r ? (m_src ? "R3 R5" : "R5") : (m_gate ? "R7" : "R4"), core_out, e);
        cmp_bit("R8", obs_out, m_gate ? r : ud);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0] a_val;
        logic [NCH-1:0] b_val;
        logic [NCH-1:0] c_val;
        int cyc;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        pin_in = 8'h5A; user_obs_d = 1'b1; rail_pin = 1'b1;
        #1;
        cmp_vec("R1", core_out, 8'h5A);
        cmp_bit("R1", obs_out, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cmp_vec("R1", core_out, 8'h5A);
        cmp_bit("R1", obs_out, 1'b1);

        // sweep over all modes and masks (R2 R3 R4 R5 R7 R8)
        cyc = 0;
        for (int md = 0; md < 4; md++) begin
            for (int mk = 0; mk < 256; mk++) begin
                step(8'(cyc * 37 + 11), 1'b0, cyc[0], 1'b1, md[1], md[0], 8'(mk));
                for (int k = 0; k < 6; k++) begin
                    cyc++;
                    step(8'((cyc * 37 + 11) ^ (cyc >> 2)), 1'((cyc * 5) >> 2),
                         cyc[1], 1'b0, md[1], md[0], 8'(mk));
                end
                cyc++;
            end
        end

        // R6: pin changes in the cycle the rail rises
        a_val = 8'hC3; b_val = 8'h3C; c_val = 8'h99;
        step(a_val, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
        step(a_val, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF);
        @(negedge clk);
        pin_in = b_val; rail_pin = 1'b1;
        #1;
        cmp_vec("R6", core_out, a_val);
        cmp_bit("R8", obs_out, 1'b1);
        @(negedge clk);
        pin_in = c_val;
        #1;
        cmp_vec("R5", core_out, a_val);
        // R7: release follows pin at once
        @(negedge clk);
        rail_pin = 1'b0;
        #1;
        cmp_vec("R7", core_out, c_val);

        // R9: channel added to mask while rail is high
        step(a_val, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
        step(a_val, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        step(b_val, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hF0);
        @(negedge clk);
        pin_in = c_val; cfg_we = 1'b0;
        #1;
        cmp_vec("R9", core_out, (a_val & 8'hF0) | (c_val & 8'h0F));

        // R2: write takes effect the cycle after the strobe edge
        step(c_val, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        cfg_we = 1'b0; user_obs_d = 1'b0;
        #1;
        cmp_bit("R2", obs_out, 1'b0);
        cmp_vec("R2", core_out, c_val);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule